// File: doc/BRIEF.md
# IQ sample stream packer

The packer collects one transmit sample pair (I and Q) and one feedback-receive sample pair per input frame. Every slot is a 16-bit signed value. The two pairs are joined into a 64-bit frame, and two accepted frames in a row are fused into one 128-bit memory-bound beat. At the same time, each frame is replayed on two narrow 16-bit lanes, one lane per external memory. The transmit lane carries the transmit samples and the receive lane carries the feedback samples, each emitting I and then Q with no gap between them.

A capture is a fixed number of frames, set by `CAPTURE_LEN` (default 2,457,600 samples per slot). When the last word of the capture has left the lanes, the block pulses `done`. It then refuses input until `start` re-arms it. `in_ready` paces the source to one frame every two cycles, which is the rate the 16-bit lanes can sustain. Because beats are built from frame pairs, `CAPTURE_LEN` is meant to be even.

Top module: `iq_stream_packer`

## Requirements
- R1: In each 32-bit pair, the I sample occupies bits [15:0] and the Q sample bits [31:16]. In each 64-bit frame, the transmit pair occupies bits [31:0] and the feedback pair bits [63:32].
- R2: Two consecutively accepted frames form one beat: the earlier frame in bits [63:0], the later in bits [127:64]. `beat_valid` is high for exactly the one cycle after the second frame is accepted.
- R3: After a frame is accepted, `tx_lane_data` shows the transmit I sample in the next cycle and the transmit Q sample in the cycle after, with `tx_lane_valid` high in both cycles.
- R4: `fb_lane_data` carries the feedback I and then Q in the same two cycles as the transmit lane, with `fb_lane_valid` equal to `tx_lane_valid`.
- R5: A frame is accepted only in a cycle where `in_valid` and `in_ready` are high and `start` is low. `in_ready` is low in the cycle after an accept, while the Q words are still pending.
- R6: Once `CAPTURE_LEN` frames have been accepted, `in_ready` stays low and offered frames produce no lane words and no beats, until `start`.
- R7: `done` is high for one cycle, in the same cycle as the final Q word of the capture on the lanes.
- R8: `start` clears the frame count and any held half beat. After `start`, a capture of `CAPTURE_LEN` frames runs again, and its first frame lands in the low half of a beat.
- R9: A synchronous reset drives all valid outputs and `done` low, raises `in_ready`, clears the frame count and empties the half-beat holder.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Re-arm a new capture |
| in_valid | input | 1 | Frame offered on the four slots |
| tx_i | input | 16 | Transmit in-phase sample |
| tx_q | input | 16 | Transmit quadrature sample |
| fb_i | input | 16 | Feedback-receive in-phase sample |
| fb_q | input | 16 | Feedback-receive quadrature sample |
| in_ready | output | 1 | A frame may be accepted this cycle |
| beat_valid | output | 1 | 128-bit beat present |
| beat_data | output | 128 | Two frames, earlier in the low half |
| tx_lane_valid | output | 1 | Transmit lane word present |
| tx_lane_data | output | 16 | Transmit lane word |
| fb_lane_valid | output | 1 | Feedback lane word present |
| fb_lane_data | output | 16 | Feedback lane word |
| done | output | 1 | Final word of the capture emitted |

## Verification
The bench builds the packer with `CAPTURE_LEN` = 6 and the default 16-bit slots. With this length, the end of a capture, the `done` pulse, the refusal of further frames and the re-arm by `start` are all reached within a few dozen cycles, and the bench can walk through several of them. A reset in the middle of a capture, with a half beat held and a Q word pending, shows that the next frame lands in the low half. Frames are offered both sparsely and back to back.

// File: rtl/iqp_pkg.sv
package iqp_pkg;

    localparam int unsigned IQP_SLOT_W = 16;

    typedef enum logic {
        HALF_LOW  = 1'b0,
        HALF_HIGH = 1'b1
    } half_e;

endpackage

// File: rtl/iqp_frame_join.sv
module iqp_frame_join #(
    parameter int unsigned SLOT_W = iqp_pkg::IQP_SLOT_W,
    localparam int unsigned PAIR_W = 2 * SLOT_W,
    localparam int unsigned FRAME_W = 2 * PAIR_W
) (
    input  logic [SLOT_W-1:0]  tx_i,
    input  logic [SLOT_W-1:0]  tx_q,
    input  logic [SLOT_W-1:0]  fb_i,
    input  logic [SLOT_W-1:0]  fb_q,
    output logic [FRAME_W-1:0] frame
);

    logic [PAIR_W-1:0] tx_pair;
    logic [PAIR_W-1:0] fb_pair;

    // I low, Q high inside a pair; transmit pair low inside a frame
    assign tx_pair = {tx_q, tx_i};
    assign fb_pair = {fb_q, fb_i};
    assign frame   = {fb_pair, tx_pair};

endmodule

// File: rtl/iqp_beat_pair.sv
module iqp_beat_pair #(
    parameter int unsigned FRAME_W = 4 * iqp_pkg::IQP_SLOT_W,
    localparam int unsigned BEAT_W = 2 * FRAME_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clear,
    input  logic               load,
    input  logic [FRAME_W-1:0] frame,
    output logic               beat_valid,
    output logic [BEAT_W-1:0]  beat_data
);
    import iqp_pkg::*;

    typedef struct packed {
        half_e              half;
        logic [FRAME_W-1:0] low;
        logic               vld;
        logic [BEAT_W-1:0]  dat;
    } pair_st_t;

    pair_st_t pair_d, pair_q;

    always_comb begin
        pair_d     = pair_q;
        pair_d.vld = 1'b0;
        if (clear) begin
            pair_d.half = HALF_LOW;
        end else if (load) begin
            if (pair_q.half == HALF_LOW) begin
                pair_d.low  = frame;
                pair_d.half = HALF_HIGH;
            end else begin
                pair_d.dat  = {frame, pair_q.low};
                pair_d.vld  = 1'b1;
                pair_d.half = HALF_LOW;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) pair_q <= '0;
        else     pair_q <= pair_d;
    end

    assign beat_valid = pair_q.vld;
    assign beat_data  = pair_q.dat;

    // R2: a beat needs two frames, and frames are at least two cycles apart
    a_r2_beat_single: assert property (@(posedge clk) disable iff (rst)
        beat_valid |=> !beat_valid);

endmodule

// File: rtl/iqp_lane_ser.sv
module iqp_lane_ser #(
    parameter int unsigned SLOT_W = iqp_pkg::IQP_SLOT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [SLOT_W-1:0] i_word,
    input  logic [SLOT_W-1:0] q_word,
    output logic              busy,
    output logic              lane_valid,
    output logic [SLOT_W-1:0] lane_data
);

    typedef struct packed {
        logic              pend;
        logic [SLOT_W-1:0] hold;
        logic              vld;
        logic [SLOT_W-1:0] dat;
    } ser_st_t;

    ser_st_t ser_d, ser_q;

    always_comb begin
        ser_d     = ser_q;
        ser_d.vld = 1'b0;
        if (ser_q.pend) begin
            ser_d.vld  = 1'b1;
            ser_d.dat  = ser_q.hold;
            ser_d.pend = 1'b0;
        end else if (load) begin
            ser_d.vld  = 1'b1;
            ser_d.dat  = i_word;
            ser_d.hold = q_word;
            ser_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ser_q <= '0;
        else     ser_q <= ser_d;
    end

    assign busy       = ser_q.pend;
    assign lane_valid = ser_q.vld;
    assign lane_data  = ser_q.dat;

    // R3: a loaded frame yields two lane words in back-to-back cycles
    a_r3_pair_gapless: assert property (@(posedge clk) disable iff (rst)
        load |=> lane_valid ##1 lane_valid);

    // R5: the controller never loads while the Q word is still pending
    a_r5_load_when_idle: assert property (@(posedge clk) disable iff (rst)
        load |-> !busy);

endmodule

// File: rtl/iqp_capture_ctl.sv
module iqp_capture_ctl #(
    parameter int unsigned CAPTURE_LEN = 2457600,
    localparam int unsigned CNT_W = $clog2(CAPTURE_LEN + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic in_valid,
    input  logic lanes_busy,
    output logic in_ready,
    output logic accept,
    output logic done
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             fin;
        logic             last_pend;
        logic             done;
    } ctl_st_t;

    ctl_st_t ctl_d, ctl_q;

    assign in_ready = !lanes_busy && !ctl_q.fin;
    assign accept   = in_valid && in_ready && !start;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        if (lanes_busy && ctl_q.last_pend) begin
            ctl_d.done      = 1'b1;
            ctl_d.last_pend = 1'b0;
        end
        if (start) begin
            ctl_d.cnt = '0;
            ctl_d.fin = 1'b0;
        end else if (accept) begin
            if (ctl_q.cnt == CNT_W'(CAPTURE_LEN - 1)) begin
                ctl_d.cnt       = CNT_W'(CAPTURE_LEN);
                ctl_d.fin       = 1'b1;
                ctl_d.last_pend = 1'b1;
            end else begin
                ctl_d.cnt = ctl_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ctl_q <= '0;
        else     ctl_q <= ctl_d;
    end

    assign done = ctl_q.done;

    // R7: the completion flag is a single-cycle pulse
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6: the frame count never passes the capture length
    a_r6_count_bound: assert property (@(posedge clk) disable iff (rst)
        ctl_q.cnt <= CNT_W'(CAPTURE_LEN));

    // R6: a finished capture stays finished until start
    a_r6_hold_finished: assert property (@(posedge clk) disable iff (rst)
        ctl_q.fin && !start |=> ctl_q.fin);

endmodule

// File: rtl/iq_stream_packer.sv
module iq_stream_packer #(
    parameter int unsigned SLOT_W      = iqp_pkg::IQP_SLOT_W,
    parameter int unsigned CAPTURE_LEN = 2457600,
    localparam int unsigned FRAME_W = 4 * SLOT_W,
    localparam int unsigned BEAT_W  = 2 * FRAME_W,
    localparam int unsigned LANES   = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    input  logic                     in_valid,
    input  logic signed [SLOT_W-1:0] tx_i,
    input  logic signed [SLOT_W-1:0] tx_q,
    input  logic signed [SLOT_W-1:0] fb_i,
    input  logic signed [SLOT_W-1:0] fb_q,
    output logic                     in_ready,
    output logic                     beat_valid,
    output logic [BEAT_W-1:0]        beat_data,
    output logic                     tx_lane_valid,
    output logic [SLOT_W-1:0]        tx_lane_data,
    output logic                     fb_lane_valid,
    output logic [SLOT_W-1:0]        fb_lane_data,
    output logic                     done
);

    logic [FRAME_W-1:0] frame;
    logic               accept;

    logic [LANES-1:0][SLOT_W-1:0] lane_i, lane_q, lane_dat;
    logic [LANES-1:0]             lane_vld, lane_busy;

    iqp_frame_join #(.SLOT_W(SLOT_W)) u_join (
        .tx_i (tx_i),
        .tx_q (tx_q),
        .fb_i (fb_i),
        .fb_q (fb_q),
        .frame(frame)
    );

    iqp_capture_ctl #(.CAPTURE_LEN(CAPTURE_LEN)) u_ctl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .in_valid  (in_valid),
        .lanes_busy(|lane_busy),
        .in_ready  (in_ready),
        .accept    (accept),
        .done      (done)
    );

    iqp_beat_pair #(.FRAME_W(FRAME_W)) u_pair (
        .clk       (clk),
        .rst       (rst),
        .clear     (start),
        .load      (accept),
        .frame     (frame),
        .beat_valid(beat_valid),
        .beat_data (beat_data)
    );

    // lane 0 carries transmit samples, lane 1 feedback-receive samples
    assign lane_i[0] = tx_i;
    assign lane_q[0] = tx_q;
    assign lane_i[1] = fb_i;
    assign lane_q[1] = fb_q;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        iqp_lane_ser #(.SLOT_W(SLOT_W)) u_ser (
            .clk       (clk),
            .rst       (rst),
            .load      (accept),
            .i_word    (lane_i[g]),
            .q_word    (lane_q[g]),
            .busy      (lane_busy[g]),
            .lane_valid(lane_vld[g]),
            .lane_data (lane_dat[g])
        );
    end

    assign tx_lane_valid = lane_vld[0];
    assign tx_lane_data  = lane_dat[0];
    assign fb_lane_valid = lane_vld[1];
    assign fb_lane_data  = lane_dat[1];

    // R4: both memory lanes run in lockstep
    a_r4_lanes_aligned: assert property (@(posedge clk) disable iff (rst)
        tx_lane_valid == fb_lane_valid);

    // R2: a beat follows an accepted frame
    a_r2_beat_after_accept: assert property (@(posedge clk) disable iff (rst)
        beat_valid |-> $past(accept));

    // R7: done coincides with a lane word
    a_r7_done_with_word: assert property (@(posedge clk) disable iff (rst)
        done |-> tx_lane_valid);

endmodule

// File: tb/test_iq_stream_packer.sv
module test_iq_stream_packer;

    localparam int SW  = 16;
    localparam int CAP = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          in_valid = 1'b0;
    logic [SW-1:0] tx_i = '0, tx_q = '0, fb_i = '0, fb_q = '0;
    logic          in_ready, beat_valid, tx_lane_valid, fb_lane_valid, done;
    logic [127:0]  beat_data;
    logic [SW-1:0] tx_lane_data, fb_lane_data;

    always #2 clk = ~clk;

    iq_stream_packer #(.SLOT_W(SW), .CAPTURE_LEN(CAP)) i_iq_stream_packer (
        .clk(clk), .rst(rst), .start(start), .in_valid(in_valid),
        .tx_i(tx_i), .tx_q(tx_q), .fb_i(fb_i), .fb_q(fb_q),
        .in_ready(in_ready), .beat_valid(beat_valid), .beat_data(beat_data),
        .tx_lane_valid(tx_lane_valid), .tx_lane_data(tx_lane_data),
        .fb_lane_valid(fb_lane_valid), .fb_lane_data(fb_lane_data),
        .done(done)
    );

    int errors = 0;
    int checks = 0;
    int seq    = 0;

    // behavioural reference state
    logic [SW-1:0]  exp_tx[$];
    logic [SW-1:0]  exp_fb[$];
    logic [127:0]   exp_beat[$];
    int             m_cnt, m_words;
    bit             m_fin, m_half, m_busy;
    logic [63:0]    m_low;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic model_clear();
        exp_tx.delete(); exp_fb.delete(); exp_beat.delete();
        m_cnt = 0; m_words = 0; m_fin = 0; m_half = 0; m_busy = 0; m_low = '0;
    endtask

    // compare outputs of the last posedge with the reference
    task automatic observe();
        logic [SW-1:0]  e16;
        logic [127:0]   e128;
        bit             exp_done;
        exp_done = 1'b0;
        chk(tx_lane_valid == fb_lane_valid, "R4", "lane valids differ",
            128'(fb_lane_valid), 128'(tx_lane_valid));
        if (tx_lane_valid) begin
            if (exp_tx.size() == 0) chk(0, "R6", "unexpected tx word", 128'(tx_lane_data), 0);
            else begin e16 = exp_tx.pop_front(); chk(tx_lane_data == e16, "R3", "tx lane word", 128'(tx_lane_data), 128'(e16)); end
            m_words++;
            exp_done = (m_words == 2 * CAP);
        end else if (exp_tx.size() != 0) begin
            chk(0, "R3", "missing tx word", 0, 128'(exp_tx[0]));
        end
        if (fb_lane_valid) begin
            if (exp_fb.size() == 0) chk(0, "R6", "unexpected fb word", 128'(fb_lane_data), 0);
            else begin e16 = exp_fb.pop_front(); chk(fb_lane_data == e16, "R4", "fb lane word", 128'(fb_lane_data), 128'(e16)); end
        end
        if (beat_valid) begin
            if (exp_beat.size() == 0) chk(0, "R2", "unexpected beat", beat_data, 0);
            else begin e128 = exp_beat.pop_front(); chk(beat_data == e128, "R1 R2", "beat layout", beat_data, e128); end
        end else if (exp_beat.size() != 0) begin
            chk(0, "R2", "missing beat", 0, exp_beat[0]);
        end
        chk(done == exp_done, "R7", "done pulse", 128'(done), 128'(exp_done));
    endtask

    task automatic step(input bit v, input bit st);
        logic [63:0] fr;
        bit          acc;
        @(negedge clk);
        observe();
        chk(in_ready == (!m_fin && !m_busy), m_fin ? "R6" : "R5", "in_ready",
            128'(in_ready), 128'(!m_fin && !m_busy));
        seq++;
        in_valid = v;
        start    = st;
        tx_i = 16'(seq * 3 + 1);
        tx_q = 16'(32'h8000 ^ seq);
        fb_i = 16'(seq * 5 + 7);
        fb_q = 16'(~seq);
        acc = v && in_ready && !st;
        if (st) begin
            m_cnt = 0; m_fin = 0; m_half = 0; m_words = 0;
        end else if (acc) begin
            fr = {fb_q, fb_i, tx_q, tx_i};
            exp_tx.push_back(tx_i); exp_tx.push_back(tx_q);
            exp_fb.push_back(fb_i); exp_fb.push_back(fb_q);
            if (m_half) begin exp_beat.push_back({fr, m_low}); m_half = 0; end
            else begin m_low = fr; m_half = 1; end
            m_cnt++;
            if (m_cnt == CAP) m_fin = 1;
        end
        m_busy = acc;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0; start = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        model_clear();
        // R9: outputs cleared, ready raised
        chk(!tx_lane_valid && !fb_lane_valid && !beat_valid && !done, "R9",
            "valids after reset", {tx_lane_valid, fb_lane_valid, beat_valid, done}, 0);
        chk(in_ready == 1'b1, "R9", "in_ready after reset", 128'(in_ready), 1);
    endtask

    initial begin
        model_clear();
        do_reset();

        // sparse offers, first capture
        for (int k = 0; k < 60 && !m_fin; k++) step((k % 3) != 1, 1'b0);
        // offers after completion are refused (R6)
        for (int k = 0; k < 10; k++) step(1'b1, 1'b0);

        // R8: restart, offer in the start cycle is not taken
        step(1'b1, 1'b1);
        for (int k = 0; k < 40 && !m_fin; k++) step(1'b1, 1'b0);
        for (int k = 0; k < 4; k++) step(1'b0, 1'b0);

        // partial capture then reset with a half beat and a Q word held (R9)
        step(1'b0, 1'b1);
        for (int k = 0; k < 5; k++) step(1'b1, 1'b0);
        do_reset();
        for (int k = 0; k < 40 && !m_fin; k++) step((k % 4) != 3, 1'b0);
        for (int k = 0; k < 6; k++) step(1'b1, 1'b0);

        // R8: start in the middle of a capture drops the held half beat
        step(1'b0, 1'b1);
        for (int k = 0; k < 3; k++) step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        step(1'b0, 1'b1);
        for (int k = 0; k < 40 && !m_fin; k++) step(1'b1, 1'b0);
        for (int k = 0; k < 6; k++) step(1'b0, 1'b0);

        chk(exp_tx.size() == 0 && exp_beat.size() == 0, "R3", "words left over",
            128'(exp_tx.size()), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog R5 actual=hung expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule